// File: doc/BRIEF.md
# Processor activity watchdog timer

This block supervises a processor through a single activity line that firmware must flip at regular intervals. Every rising or falling change on that line restarts a countdown. If the countdown runs out, the active-low expired output drops and stays low until the line moves again. That output can drive the manual-reset input of a reset generator, so a stalled processor gets restarted.

The timer stays cleared and idle in two cases: while system reset is asserted, and while a separate flag reports that the activity line is floating or tristated. While it is idle the output reads high. When neither condition holds, the countdown does not start straight away. It begins at the first change seen on the line. The timeout length is a parameter counted in clock cycles.

The activity line passes through a flop synchronizer. A change on it reaches the timer two clocks after the clock edge that first samples it.

Top module: `act_watchdog`

## Requirements
- R1: While rst_ni is low, and right after it rises, expired_no is high.
- R2: Every rising change and every falling change of kick_i counts as a kick. A high pulse lasting one clock gives two kicks, one per edge. A kick is registered two clock edges after the edge that first samples the new level.
- R3: Let clock edge k be the first edge to sample the last change on kick_i. With no further change, expired_no is still high after edge k+T+1 and low after edge k+T+2, where T is TIMEOUT_CYCLES.
- R4: Once low, expired_no stays low for as long as kick_i holds still. A change first sampled at edge k brings expired_no high after edge k+2.
- R5: While sys_rst_i is high the timer is cleared. expired_no is high after the first clock edge that samples sys_rst_i high.
- R6: While float_i is high the timer is cleared. expired_no is high after the first clock edge that samples float_i high.
- R7: After sys_rst_i or float_i is released, no countdown runs until a change on kick_i is registered. If kick_i holds still, expired_no stays high without limit.
- R8: Each registered kick restarts the countdown from zero. Kicks spaced fewer than T clocks apart keep expired_no high.
- R9: Changes on kick_i that are registered while the timer is cleared do not arm it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| sys_rst_i | input | 1 | System reset asserted; clears and disables the timer |
| float_i | input | 1 | Activity line is floating or tristated; clears and disables the timer |
| kick_i | input | 1 | Activity line toggled by the processor, asynchronous |
| expired_no | output | 1 | Low when the timeout has elapsed with no kick |

## Verification
A miscounted or badly compared counter moves the falling edge of expired_no away from edge k+T+2. The bench measures that edge to the exact clock. An arm flag that is set too early, or never cleared, shows up as expired_no falling after a release with no kick, within T+2 clocks of the release. A lost edge detect has two visible effects: expired_no fails to recover two clocks after a change, and a stream of kicks no longer holds the output high.

// File: rtl/act_wdt_pkg.sv
package act_wdt_pkg;
  localparam int unsigned DEF_TIMEOUT_CYCLES = 400_000_000; // 1.6 s at 250 MHz
  localparam int unsigned DEF_SYNC_STAGES    = 2;
endpackage

// File: rtl/act_wdt_edge.sv
module act_wdt_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic edge_o
);
  logic [STAGES-1:0] sr_q;
  logic              prev_q;
  logic [STAGES:0]   fill_q; // suppress edges until sync chain holds real data

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q[0] <= 1'b0;
    else         sr_q[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sr_q[i] <= 1'b0;
      else         sr_q[i] <= sr_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      fill_q <= '0;
    end else begin
      prev_q <= sr_q[STAGES-1];
      fill_q <= {fill_q[STAGES-1:0], 1'b1};
    end
  end

  assign edge_o = fill_q[STAGES] & (sr_q[STAGES-1] ^ prev_q);
endmodule

// File: rtl/act_wdt_timer.sv
module act_wdt_timer #(
  parameter int unsigned TIMEOUT_CYCLES = 400_000_000,
  localparam int unsigned CNT_W = (TIMEOUT_CYCLES < 2) ? 1 : $clog2(TIMEOUT_CYCLES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             kick_i,
  output logic             armed_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expired_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  logic             armed_q, exp_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      exp_q   <= 1'b0;
      cnt_q   <= '0;
    end else if (clear_i) begin
      armed_q <= 1'b0;
      exp_q   <= 1'b0;
      cnt_q   <= '0;
    end else if (kick_i) begin
      armed_q <= 1'b1;
      exp_q   <= 1'b0;
      cnt_q   <= '0;
    end else if (armed_q && !exp_q) begin
      if (cnt_q == LAST) exp_q <= 1'b1;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign armed_o   = armed_q;
  assign cnt_o     = cnt_q;
  assign expired_o = exp_q;
endmodule

// File: rtl/act_watchdog.sv
module act_watchdog
  import act_wdt_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = DEF_TIMEOUT_CYCLES,
  parameter int unsigned SYNC_STAGES    = DEF_SYNC_STAGES,
  localparam int unsigned CNT_W = (TIMEOUT_CYCLES < 2) ? 1 : $clog2(TIMEOUT_CYCLES)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sys_rst_i,
  input  logic float_i,
  input  logic kick_i,
  output logic expired_no
);
  logic             kick_edge;
  logic             clear;
  logic             armed;
  logic             expired;
  logic [CNT_W-1:0] cnt;

  assign clear = sys_rst_i | float_i;

  act_wdt_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (kick_i),
    .edge_o (kick_edge)
  );

  act_wdt_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clear),
    .kick_i    (kick_edge),
    .armed_o   (armed),
    .cnt_o     (cnt),
    .expired_o (expired)
  );

  assign expired_no = ~expired;
endmodule

// File: rtl/act_watchdog_chk.sv
module act_watchdog_chk #(
  parameter int unsigned TIMEOUT_CYCLES = 400_000_000,
  localparam int unsigned CNT_W = (TIMEOUT_CYCLES < 2) ? 1 : $clog2(TIMEOUT_CYCLES)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sys_rst_i,
  input logic             float_i,
  input logic             expired_no,
  input logic             edge_i,
  input logic             armed_i,
  input logic [CNT_W-1:0] cnt_i
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  // R5 / R6: a disable cycle leaves the output high
  p_disable_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_i || float_i) |=> expired_no);

  p_hold_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!expired_no && !edge_i && !sys_rst_i && !float_i) |=> !expired_no);

  p_kick_release_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_i |=> expired_no);

  p_expire_at_limit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(expired_no) |-> ($past(cnt_i) == LAST && $past(armed_i)));

  p_cnt_in_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= LAST);

  p_unarmed_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_i |-> expired_no);
endmodule

bind act_watchdog act_watchdog_chk #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sys_rst_i  (sys_rst_i),
  .float_i    (float_i),
  .expired_no (expired_no),
  .edge_i     (kick_edge),
  .armed_i    (armed),
  .cnt_i      (cnt)
);

// File: tb/tb_act_watchdog.sv
`timescale 1ns/1ps
module tb_act_watchdog;
  localparam int unsigned T = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sys_rst = 1'b0;
  logic flt = 1'b0;
  logic kick = 1'b0;
  logic exp_n;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk; // 250 MHz

  act_watchdog #(.TIMEOUT_CYCLES(T)) dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .sys_rst_i  (sys_rst),
    .float_i    (flt),
    .kick_i     (kick),
    .expired_no (exp_n)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic exp);
    n_chk++;
    if (exp_n !== exp) begin
      n_bad++;
      $display("FAIL %s: expired_no=%b expected %b at %0t", req, exp_n, exp, $time);
    end
  endtask

  task automatic clear_timer();
    sys_rst = 1'b1; step(3); sys_rst = 1'b0; step(3);
  endtask

  task automatic t_reset();
    check("R1", 1'b1);
    step(2); rst_n = 1'b1; step(1);
    check("R1", 1'b1);
  endtask

  task automatic t_no_arm();
    clear_timer();
    step(T + 10);
    check("R7", 1'b1);
  endtask

  task automatic t_expire();
    clear_timer();
    kick = ~kick; step(T + 2);
    check("R3", 1'b1);
    step(1);
    check("R3", 1'b0);
    kick = ~kick; step(T + 2); // falling change also kicks
    check("R2", 1'b1);
    step(1);
    check("R2", 1'b0);
  endtask

  task automatic t_latch();
    step(3 * T);
    check("R4", 1'b0);
    kick = ~kick; step(2);
    check("R4", 1'b0);
    step(1);
    check("R4", 1'b1);
  endtask

  task automatic t_restart();
    clear_timer();
    for (int i = 0; i < 8; i++) begin
      kick = ~kick; step(T - 4);
    end
    check("R8", 1'b1);
    step(6);
    check("R8", 1'b1);
    step(1);
    check("R8", 1'b0);
  endtask

  task automatic t_pulse();
    clear_timer();
    kick = ~kick; step(1); kick = ~kick;
    step(T + 2);
    check("R2", 1'b1);
    step(1);
    check("R2", 1'b0);
  endtask

  task automatic t_sysrst();
    clear_timer();
    kick = ~kick; step(T + 3);
    check("R5", 1'b0);
    sys_rst = 1'b1; step(1);
    check("R5", 1'b1);
    step(4); sys_rst = 1'b0;
    step(T + 10);
    check("R7", 1'b1);
  endtask

  task automatic t_float();
    clear_timer();
    kick = ~kick; step(T + 3);
    check("R6", 1'b0);
    flt = 1'b1; step(1);
    check("R6", 1'b1);
    kick = ~kick; step(2); kick = ~kick; step(6);
    check("R6", 1'b1);
    flt = 1'b0;
    step(T + 10);
    check("R9", 1'b1);
  endtask

  initial begin
    step(20_000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_no_arm();
    t_expire();
    t_latch();
    t_restart();
    t_pulse();
    t_sysrst();
    t_float();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule